// File: doc/BRIEF.md
# Interconnect Error Capture Register Block

This block sits beside a coherent interconnect and records the error events it reports. Four kinds of error arrive as single-cycle strobes: local access error, coherency violation, unavailable target and multicast stash. All four share one payload bus carrying an 8-bit source ID, a 5-bit capture type and a 40-bit transaction address. Each accepted strobe sets a sticky detect flag for its kind. The first accepted error after the capture registers are armed also freezes its payload for software to read.

Software reaches the block through a simple 32-bit register port. The port decodes a byte offset, writes in one cycle, and returns read data one cycle after the read strobe. A level interrupt stays high while any detect flag is set whose interrupt enable is also set.

The parameter `PERSONALITY` selects one of two register layouts:
- **Personality 0** uses one combined enable register that gates both detection and the interrupt. The capture-valid bit sits in the attribute register.
- **Personality 1** has a per-bit detect-disable register and a separate interrupt-enable register. The capture-valid bit and the capture type sit in the detect register.

Top module: `icx_err_capture`

## Requirements
- R1: After a synchronous reset, every register reads 0, `irq` is low and no capture is held.
- R2: The detect register holds one sticky flag per error kind, at these bit positions: bit 0 local access error, bit 1 coherency violation, bit 2 unavailable target, bit 3 multicast stash. A flag sets at the clock edge that samples an accepted strobe and stays set until software clears it.
- R3: Detect flags are write-one-to-clear: a 1 in a written bit clears that flag and a 0 leaves it alone. An accepted strobe in the same cycle as the clear wins, and the flag stays set.
- R4: The first accepted error after arming captures its source ID, capture type and 40-bit address. The address reads back with bits 31:0 at offset 0x14 and bits 39:32 in bits 7:0 of offset 0x10, and the capture type reads back in bits 4:0 of offset 0x18. Later errors set their flags but leave the capture unchanged.
- R5: Clearing the capture-valid bit re-arms the capture, so the next accepted error is recorded. The clear is a write of 1 to attribute bit 0 in personality 0, or a write of 1 to detect bit 31 in personality 1.
- R6: When several kinds strobe in one cycle, all accepted flags set and the capture records the lowest-numbered accepted kind.
- R7: `irq` is a level output. It is high exactly while some detect flag and its interrupt enable are both set, and it changes at the same clock edge as the registers it depends on.
- R8: In personality 0, offset 0x04 is a combined enable. A kind whose bit is 0 is neither detected nor able to interrupt, and writing 0 drops `irq` while the flags remain. Offset 0x08 reads 0 and ignores writes.
- R9: In personality 1, a 1 in bit k of offset 0x04 stops kind k from being detected, and offset 0x08 holds the interrupt enables. A kind whose interrupt enable is 0 still sets its detect flag.
- R10: In personality 0, the attribute register at 0x0C holds capture-valid in bit 0, the source ID in bits 31:24, and bit 15 set when the captured kind is unavailable target (kind 2).
- R11: In personality 1, detect bit 31 is capture-valid and detect bits 30:26 hold the capture type while valid (0 otherwise). Attribute bits 25:18 hold the source ID.
- R12: `reg_rvalid` pulses exactly one cycle after `reg_rd`, with `reg_rdata` valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_vld | input | N_TYPES | One strobe per error kind |
| evt_src | input | SRC_W | Source ID of the failing transaction |
| evt_ctype | input | CTYPE_W | Capture type of the failing transaction |
| evt_addr | input | ADDR_W | Address of the failing transaction |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | REG_AW | Byte offset of the register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, registered |
| reg_rvalid | output | 1 | Read data valid |
| irq | output | 1 | Level interrupt |

## Verification
The bench drives both personalities side by side.

It fires a second error while a capture is held. A design that overwrote on every error would show the newer address. It also clears a flag in the same cycle its strobe returns. A design that let the clear win would read the flag as 0.

It strobes three kinds at once with one of them disabled. A wrong priority or a missing gate shows up in the detect value and in the unavailable-target bit. It also clears the valid bit and then fires again, which exposes a capture that never re-arms.

It also turns interrupt enables off while flags remain. An interrupt tied to the flags alone would stay high, and one tied to the enables alone would rise with no flag set.

// File: rtl/icx_err_pkg.sv
package icx_err_pkg;
  // word index = byte offset / 4
  typedef enum logic [2:0] {
    RI_DETECT  = 3'd0,
    RI_GATE    = 3'd1,
    RI_IRQEN   = 3'd2,
    RI_ATTR    = 3'd3,
    RI_ADDR_HI = 3'd4,
    RI_ADDR_LO = 3'd5,
    RI_ATTR2   = 3'd6,
    RI_NONE    = 3'd7
  } reg_idx_e;

  localparam int unsigned CAPV_A_BIT  = 0;
  localparam int unsigned NOTGT_A_BIT = 15;
  localparam int unsigned SRC_A_LSB   = 24;
  localparam int unsigned SRC_B_LSB   = 18;
  localparam int unsigned CAPV_B_BIT  = 31;
  localparam int unsigned CTYPE_B_LSB = 26;
  localparam int unsigned NOTGT_KIND  = 2;
endpackage

// File: rtl/icx_err_detect.sv
module icx_err_detect #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt_vld,
  input  logic [N-1:0] det_gate,
  input  logic [N-1:0] clr,
  output logic [N-1:0] accepted,
  output logic [N-1:0] det_d,
  output logic [N-1:0] det_q
);
  assign accepted = evt_vld & det_gate;
  // new events override a simultaneous clear
  assign det_d    = (det_q & ~clr) | accepted;

  always_ff @(posedge clk) begin
    if (rst) det_q <= '0;
    else     det_q <= det_d;
  end
endmodule

// File: rtl/icx_err_capture_unit.sv
module icx_err_capture_unit #(
  parameter int N  = 4,
  parameter int AW = 40,
  parameter int SW = 8,
  parameter int TW = 5,
  parameter int KW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  accepted,
  input  logic [SW-1:0] src,
  input  logic [TW-1:0] ctype,
  input  logic [AW-1:0] addr,
  input  logic          rearm,
  output logic          cap_vld,
  output logic [SW-1:0] cap_src,
  output logic [TW-1:0] cap_ctype,
  output logic [AW-1:0] cap_addr,
  output logic [KW-1:0] cap_kind
);
  logic          hit;
  logic          armed;
  logic [KW-1:0] kind_d;

  always_comb begin
    hit    = |accepted;
    kind_d = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (accepted[i]) kind_d = KW'(i);
    end
  end

  assign armed = !cap_vld || rearm;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_vld   <= 1'b0;
      cap_src   <= '0;
      cap_ctype <= '0;
      cap_addr  <= '0;
      cap_kind  <= '0;
    end else if (armed && hit) begin
      cap_vld   <= 1'b1;
      cap_src   <= src;
      cap_ctype <= ctype;
      cap_addr  <= addr;
      cap_kind  <= kind_d;
    end else if (rearm) begin
      cap_vld   <= 1'b0;
    end
  end
endmodule

// File: rtl/icx_err_readmux.sv
module icx_err_readmux
  import icx_err_pkg::*;
#(
  parameter int P  = 1,
  parameter int N  = 4,
  parameter int AW = 40,
  parameter int SW = 8,
  parameter int TW = 5,
  parameter int KW = 2,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd,
  input  reg_idx_e      idx,
  input  logic [N-1:0]  det_q,
  input  logic [N-1:0]  gate_rd,
  input  logic [N-1:0]  ien_rd,
  input  logic          cap_vld,
  input  logic [SW-1:0] cap_src,
  input  logic [TW-1:0] cap_ctype,
  input  logic [AW-1:0] cap_addr,
  input  logic [KW-1:0] cap_kind,
  output logic [DW-1:0] rdata_q,
  output logic          rvalid_q
);
  localparam int HI_W = AW - 32;

  logic [DW-1:0] word;

  always_comb begin
    word = '0;
    unique case (idx)
      RI_DETECT: begin
        word[N-1:0] = det_q;
        if (P != 0) begin
          word[CAPV_B_BIT] = cap_vld;
          word[CTYPE_B_LSB +: TW] = cap_vld ? cap_ctype : '0;
        end
      end
      RI_GATE:    word[N-1:0] = gate_rd;
      RI_IRQEN:   word[N-1:0] = ien_rd;
      RI_ATTR: begin
        if (P == 0) begin
          word[CAPV_A_BIT]     = cap_vld;
          word[NOTGT_A_BIT]    = cap_vld && (cap_kind == KW'(NOTGT_KIND));
          word[SRC_A_LSB +: SW] = cap_src;
        end else begin
          word[SRC_B_LSB +: SW] = cap_src;
        end
      end
      RI_ADDR_HI: word[HI_W-1:0] = cap_addr[AW-1:32];
      RI_ADDR_LO: word[31:0]     = cap_addr[31:0];
      RI_ATTR2:   word[TW-1:0]   = cap_ctype;
      default:    word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd;
      if (rd) rdata_q <= word;
    end
  end
endmodule

// File: rtl/icx_err_capture.sv
module icx_err_capture
  import icx_err_pkg::*;
#(
  parameter int PERSONALITY = 1,
  parameter int N_TYPES     = 4,
  parameter int ADDR_W      = 40,
  parameter int SRC_W       = 8,
  parameter int CTYPE_W     = 5,
  parameter int REG_AW      = 5,
  parameter int DATA_W      = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_TYPES-1:0] evt_vld,
  input  logic [SRC_W-1:0]   evt_src,
  input  logic [CTYPE_W-1:0] evt_ctype,
  input  logic [ADDR_W-1:0]  evt_addr,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               reg_rvalid,
  output logic               irq
);
  localparam int KW = (N_TYPES > 1) ? $clog2(N_TYPES) : 1;

  reg_idx_e           idx;
  logic               wr_det;
  logic [N_TYPES-1:0] clr, accepted, det_d, det_q;
  logic [N_TYPES-1:0] det_gate, irq_mask_d, gate_rd, ien_rd;
  logic               rearm;
  logic               cap_vld;
  logic [SRC_W-1:0]   cap_src;
  logic [CTYPE_W-1:0] cap_ctype;
  logic [ADDR_W-1:0]  cap_addr;
  logic [KW-1:0]      cap_kind;
  logic               unused_bits;

  assign unused_bits = ^{reg_addr, reg_wdata};
  assign idx    = reg_idx_e'(reg_addr[4:2]);
  assign wr_det = reg_wr && (idx == RI_DETECT);
  assign clr    = wr_det ? reg_wdata[N_TYPES-1:0] : '0;

  generate
    if (PERSONALITY == 0) begin : g_combined
      logic [N_TYPES-1:0] en_q, en_d;
      assign en_d = (reg_wr && idx == RI_GATE) ? reg_wdata[N_TYPES-1:0] : en_q;
      always_ff @(posedge clk) begin
        if (rst) en_q <= '0;
        else     en_q <= en_d;
      end
      assign det_gate   = en_q;
      assign irq_mask_d = en_d;
      assign gate_rd    = en_q;
      assign ien_rd     = '0;
      assign rearm      = reg_wr && (idx == RI_ATTR) && reg_wdata[CAPV_A_BIT];
    end else begin : g_split
      logic [N_TYPES-1:0] dis_q, dis_d, ien_q, ien_d;
      assign dis_d = (reg_wr && idx == RI_GATE)  ? reg_wdata[N_TYPES-1:0] : dis_q;
      assign ien_d = (reg_wr && idx == RI_IRQEN) ? reg_wdata[N_TYPES-1:0] : ien_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          dis_q <= '0;
          ien_q <= '0;
        end else begin
          dis_q <= dis_d;
          ien_q <= ien_d;
        end
      end
      assign det_gate   = ~dis_q;
      assign irq_mask_d = ien_d;
      assign gate_rd    = dis_q;
      assign ien_rd     = ien_q;
      assign rearm      = wr_det && reg_wdata[CAPV_B_BIT];
    end
  endgenerate

  icx_err_detect #(.N(N_TYPES)) u_detect (
    .clk(clk), .rst(rst), .evt_vld(evt_vld), .det_gate(det_gate), .clr(clr),
    .accepted(accepted), .det_d(det_d), .det_q(det_q)
  );

  icx_err_capture_unit #(
    .N(N_TYPES), .AW(ADDR_W), .SW(SRC_W), .TW(CTYPE_W), .KW(KW)
  ) u_capture (
    .clk(clk), .rst(rst), .accepted(accepted), .src(evt_src), .ctype(evt_ctype),
    .addr(evt_addr), .rearm(rearm), .cap_vld(cap_vld), .cap_src(cap_src),
    .cap_ctype(cap_ctype), .cap_addr(cap_addr), .cap_kind(cap_kind)
  );

  icx_err_readmux #(
    .P(PERSONALITY), .N(N_TYPES), .AW(ADDR_W), .SW(SRC_W), .TW(CTYPE_W),
    .KW(KW), .DW(DATA_W)
  ) u_readmux (
    .clk(clk), .rst(rst), .rd(reg_rd), .idx(idx), .det_q(det_q),
    .gate_rd(gate_rd), .ien_rd(ien_rd), .cap_vld(cap_vld), .cap_src(cap_src),
    .cap_ctype(cap_ctype), .cap_addr(cap_addr), .cap_kind(cap_kind),
    .rdata_q(reg_rdata), .rvalid_q(reg_rvalid)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(det_d & irq_mask_d);
  end
endmodule

// File: rtl/icx_err_capture_chk.sv
module icx_err_capture_chk #(
  parameter int N  = 4,
  parameter int AW = 40
) (
  input logic          clk,
  input logic          rst,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic          reg_rvalid,
  input logic          irq,
  input logic          cap_vld,
  input logic [N-1:0]  det_q,
  input logic [AW-1:0] cap_addr
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!irq && det_q == '0 && !cap_vld));

  p_detect_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    !reg_wr |=> ((det_q & $past(det_q)) == $past(det_q)));

  p_capture_frozen_r4: assert property (@(posedge clk) disable iff (rst)
    (cap_vld && !reg_wr) |=> (cap_vld && $stable(cap_addr)));

  p_irq_needs_flag_r7: assert property (@(posedge clk) disable iff (rst)
    (det_q == '0) |-> !irq);

  p_read_latency_r12: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> reg_rvalid);

  p_no_stray_rvalid_r12: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> !reg_rvalid);
endmodule

bind icx_err_capture icx_err_capture_chk #(.N(N_TYPES), .AW(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_rvalid(reg_rvalid), .irq(irq), .cap_vld(cap_vld), .det_q(det_q),
  .cap_addr(cap_addr)
);

// File: tb/icx_err_capture_bench.sv
module icx_err_capture_bench;
  import icx_err_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst;
  logic [3:0]  vld [2];
  logic [7:0]  src [2];
  logic [4:0]  ct  [2];
  logic [39:0] ad  [2];
  logic        wr  [2];
  logic        rd  [2];
  logic [4:0]  ra  [2];
  logic [31:0] wd  [2];
  logic [31:0] rdat[2];
  logic        rv  [2];
  logic        irq [2];

  // index 1: split personality, index 0: combined personality
  icx_err_capture #(.PERSONALITY(1)) u_icx_err_capture (
    .clk(clk), .rst(rst), .evt_vld(vld[1]), .evt_src(src[1]), .evt_ctype(ct[1]),
    .evt_addr(ad[1]), .reg_wr(wr[1]), .reg_rd(rd[1]), .reg_addr(ra[1]),
    .reg_wdata(wd[1]), .reg_rdata(rdat[1]), .reg_rvalid(rv[1]), .irq(irq[1])
  );

  icx_err_capture #(.PERSONALITY(0)) u_icx_err_capture_a (
    .clk(clk), .rst(rst), .evt_vld(vld[0]), .evt_src(src[0]), .evt_ctype(ct[0]),
    .evt_addr(ad[0]), .reg_wr(wr[0]), .reg_rd(rd[0]), .reg_addr(ra[0]),
    .reg_wdata(wd[0]), .reg_rdata(rdat[0]), .reg_rvalid(rv[0]), .irq(irq[0])
  );

  int checks = 0;
  int errors = 0;

  typedef struct {
    int          p;
    logic [31:0] v;
    string       tag;
  } exp_t;
  exp_t expq[$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as the design returns it
  always @(negedge clk) begin
    for (int p = 0; p < 2; p++) begin
      if (rv[p] === 1'b1) begin
        if (expq.size() == 0) begin
          chk("R12 unexpected read data", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = expq.pop_front();
          chk(e.tag, (e.p == p) ? rdat[p] : ~e.v, e.v);
        end
      end
    end
  end

  task automatic rd_exp(int p, reg_idx_e i, logic [31:0] v, string tag);
    @(negedge clk);
    rd[p] = 1'b1;
    ra[p] = {i, 2'b00};
    expq.push_back('{p, v, tag});
    @(negedge clk);
    rd[p] = 1'b0;
  endtask

  task automatic wr_reg(int p, reg_idx_e i, logic [31:0] v);
    @(negedge clk);
    wr[p] = 1'b1;
    ra[p] = {i, 2'b00};
    wd[p] = v;
    @(negedge clk);
    wr[p] = 1'b0;
  endtask

  task automatic fire(int p, logic [3:0] v, logic [7:0] s, logic [4:0] c,
                      logic [39:0] a);
    @(negedge clk);
    vld[p] = v; src[p] = s; ct[p] = c; ad[p] = a;
    @(negedge clk);
    vld[p] = '0;
  endtask

  task automatic fire_wr(int p, logic [3:0] v, logic [7:0] s, logic [4:0] c,
                         logic [39:0] a, reg_idx_e i, logic [31:0] w);
    @(negedge clk);
    vld[p] = v; src[p] = s; ct[p] = c; ad[p] = a;
    wr[p] = 1'b1; ra[p] = {i, 2'b00}; wd[p] = w;
    @(negedge clk);
    vld[p] = '0;
    wr[p]  = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1;
    for (int p = 0; p < 2; p++) begin
      vld[p] = '0; src[p] = '0; ct[p] = '0; ad[p] = '0;
      wr[p] = 1'b0; rd[p] = 1'b0; ra[p] = '0; wd[p] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // ---------------- split personality ----------------
    chk("R1 irq after reset (split)", 32'(irq[1]), 0);
    rd_exp(1, RI_DETECT,  0, "R1 detect reset");
    rd_exp(1, RI_ATTR,    0, "R1 attr reset");
    rd_exp(1, RI_ADDR_HI, 0, "R1 addr hi reset");
    rd_exp(1, RI_ADDR_LO, 0, "R1 addr lo reset");
    rd_exp(1, RI_ATTR2,   0, "R1 attr2 reset");
    rd_exp(1, RI_IRQEN,   0, "R1 irq enable reset");

    fire(1, 4'b0001, 8'h5A, 5'h13, 40'hAB_1234_5678);
    chk("R9 flag without irq enable keeps irq low", 32'(irq[1]), 0);
    rd_exp(1, RI_DETECT,  32'hCC00_0001, "R11 R2 detect with capture valid and type");
    rd_exp(1, RI_ATTR,    32'h0168_0000, "R11 source id at 25:18");
    rd_exp(1, RI_ADDR_HI, 32'h0000_00AB, "R4 address high byte");
    rd_exp(1, RI_ADDR_LO, 32'h1234_5678, "R4 address low word");
    rd_exp(1, RI_ATTR2,   32'h0000_0013, "R4 capture type");

    wr_reg(1, RI_IRQEN, 32'h3);
    chk("R7 irq rises on enable", 32'(irq[1]), 1);

    fire(1, 4'b0010, 8'h77, 5'h01, 40'h22_0000_0001);
    rd_exp(1, RI_DETECT,  32'hCC00_0003, "R4 second error sets flag only");
    rd_exp(1, RI_ADDR_LO, 32'h1234_5678, "R4 capture not overwritten");
    rd_exp(1, RI_ATTR,    32'h0168_0000, "R4 source not overwritten");

    wr_reg(1, RI_DETECT, 32'h1);
    rd_exp(1, RI_DETECT, 32'hCC00_0002, "R3 partial write-one-to-clear");
    chk("R7 irq held by remaining flag", 32'(irq[1]), 1);

    wr_reg(1, RI_DETECT, 32'h8000_0002);
    rd_exp(1, RI_DETECT, 32'h0, "R5 R3 full clear and re-arm");
    chk("R7 irq drops with flags", 32'(irq[1]), 0);

    wr_reg(1, RI_GATE, 32'h4);
    fire(1, 4'b0100, 8'h01, 5'h01, 40'h1);
    rd_exp(1, RI_DETECT, 32'h0, "R9 disabled kind not detected");
    chk("R9 disabled kind no irq", 32'(irq[1]), 0);

    fire(1, 4'b1110, 8'h3C, 5'h07, 40'h00_CAFE_F00D);
    rd_exp(1, RI_DETECT,  32'h9C00_000A, "R6 simultaneous strobes with one disabled");
    rd_exp(1, RI_ATTR,    32'h00F0_0000, "R5 re-armed capture source");
    rd_exp(1, RI_ADDR_LO, 32'hCAFE_F00D, "R5 re-armed capture address");
    rd_exp(1, RI_ADDR_HI, 32'h0, "R4 address high zero");
    chk("R7 irq from enabled flag", 32'(irq[1]), 1);

    fire_wr(1, 4'b0010, 8'h99, 5'h02, 40'h5, RI_DETECT, 32'h2);
    rd_exp(1, RI_DETECT, 32'h9C00_000A, "R3 event beats same-cycle clear");
    rd_exp(1, RI_GATE,   32'h4, "R9 disable register readback");
    rd_exp(1, RI_IRQEN,  32'h3, "R9 irq enable readback");

    // ---------------- combined personality ----------------
    chk("R1 irq after reset (combined)", 32'(irq[0]), 0);
    rd_exp(0, RI_GATE,   0, "R1 enable reset");
    rd_exp(0, RI_DETECT, 0, "R1 detect reset combined");

    fire(0, 4'b0001, 8'h10, 5'h01, 40'h1);
    rd_exp(0, RI_DETECT, 0, "R8 not detected while enable is 0");
    chk("R8 no irq while disabled", 32'(irq[0]), 0);

    wr_reg(0, RI_GATE, 32'hF);
    rd_exp(0, RI_GATE, 32'hF, "R8 enable readback");
    wr_reg(0, RI_IRQEN, 32'hF);
    rd_exp(0, RI_IRQEN, 32'h0, "R8 offset 0x08 reads zero");

    fire(0, 4'b1100, 8'hC3, 5'h09, 40'h01_DEAD_BEEF);
    chk("R7 irq combined", 32'(irq[0]), 1);
    rd_exp(0, RI_DETECT,  32'h0000_000C, "R2 two flags");
    rd_exp(0, RI_ATTR,    32'hC300_8001, "R10 R6 valid, no-target kind, source");
    rd_exp(0, RI_ADDR_HI, 32'h0000_0001, "R4 address high combined");
    rd_exp(0, RI_ADDR_LO, 32'hDEAD_BEEF, "R4 address low combined");
    rd_exp(0, RI_ATTR2,   32'h0000_0009, "R4 capture type combined");

    fire(0, 4'b0001, 8'h55, 5'h03, 40'h77);
    rd_exp(0, RI_DETECT,  32'h0000_000D, "R2 later flag added");
    rd_exp(0, RI_ATTR,    32'hC300_8001, "R4 capture held combined");

    wr_reg(0, RI_ATTR, 32'h1);
    rd_exp(0, RI_ATTR, 32'hC300_0000, "R5 valid cleared by attr write");

    fire(0, 4'b0110, 8'h11, 5'h02, 40'h40);
    rd_exp(0, RI_ATTR,    32'h1100_0001, "R6 lowest kind wins, no no-target bit");
    rd_exp(0, RI_ADDR_LO, 32'h0000_0040, "R5 new capture address");
    rd_exp(0, RI_ADDR_HI, 32'h0, "R5 new capture high");
    rd_exp(0, RI_ATTR2,   32'h2, "R5 new capture type");

    wr_reg(0, RI_GATE, 32'h0);
    chk("R8 enable 0 stops irq", 32'(irq[0]), 0);
    rd_exp(0, RI_DETECT, 32'h0000_000F, "R8 flags survive enable 0");

    wr_reg(0, RI_DETECT, 32'hF);
    rd_exp(0, RI_DETECT, 32'h0, "R3 clear all combined");

    repeat (3) @(negedge clk);
    chk("R12 reads outstanding", 32'(expq.size()), 0);
    summary();
    $finish;
  end
endmodule